// File: doc/BRIEF.md
# Transmit FIR De-emphasis Tap Combiner

This block shapes a serial NRZ stream for a DAC-driven line transmitter. One data bit is accepted on each cycle where the symbol-rate enable is high. A three-stage history register keeps the older bits. Each bit stands for a symbol of +1 (bit 1) or -1 (bit 0). On every enable the block registers a signed amplitude code: the sum of four signed coefficients, each multiplied by the symbol at its tap. The four taps are one advanced pre-cursor, the main cursor and two post-cursors, spaced exactly one symbol apart.

Advanced data cannot be produced causally, so the main cursor is the bit accepted one enable earlier. The bit arriving now acts as the pre-cursor, and the two older bits feed post-cursors 1 and 2. The coefficients come from four programming ports, or from a built-in preset. The presets give classic two-tap de-emphasis at about -3.5 dB and -6 dB, and a flat main-only setting.

A small controller has two states. ST_FILL holds the output at zero while the history fills after reset. The transition FILL_DONE moves it to ST_RUN on the third enable after reset. In ST_RUN every enable loads a new sum. The controller stays in ST_RUN until reset, which returns it to ST_FILL.

Top module: `txffe_combiner`

## Requirements
- R1: In free mode (mode_sel = 0), the output loaded at an enable is sat(c_pre*s0 + c_main*s1 + c_post1*s2 + c_post2*s3). Each coefficient is a signed two's-complement input and may be positive or negative. The symbol s is +1 for bit 1 and -1 for bit 0.
- R2: s0 is the bit presented with the current enable. s1, s2 and s3 are the bits presented with the 1st, 2nd and 3rd earlier enables. So a bit reaches the output through the pre-cursor on the enable it arrives, through the main cursor on the next enable, and through the post-cursors on the two enables after that.
- R3: amp_out and amp_valid change only at clock edges where ui_en is high, or on reset. Changes on bit_in, mode_sel or the coefficient inputs while ui_en is low do not affect them.
- R4: Reset clears the history to bit 0. While reset is held, amp_out is 0 and amp_valid is 0. After reset, the first three enables (ST_FILL) load 0 with amp_valid low. The fourth enable is the first in ST_RUN: it loads a real sum and raises amp_valid.
- R5: mode_sel = 1 selects the -3.5 dB preset: c_pre 0, c_main 106, c_post1 -21, c_post2 0. The coefficient inputs are ignored. A bit that differs from the one before it drives ±127. A repeated bit drives ±85.
- R6: mode_sel = 2 selects the -6 dB preset: c_main 95, c_post1 -32, others 0. A transition bit drives ±127 and a repeated bit drives ±63.
- R7: mode_sel = 3 selects main only: c_main 127, others 0. The output is +127 for a main bit of 1 and -127 for a main bit of 0, whatever the coefficient inputs.
- R8: A sum above +511 loads +511, and a sum below -511 loads -511. Sums inside this range pass unchanged.
- R9: Once raised, amp_valid stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ui_en | input | 1 | Symbol-rate enable; one bit accepted per high cycle |
| bit_in | input | 1 | Serial NRZ data bit |
| mode_sel | input | 2 | 0 free, 1 preset -3.5 dB, 2 preset -6 dB, 3 main only |
| coef_pre | input | 8 | Signed pre-cursor coefficient (free mode) |
| coef_main | input | 8 | Signed main-cursor coefficient (free mode) |
| coef_post1 | input | 8 | Signed first post-cursor coefficient (free mode) |
| coef_post2 | input | 8 | Signed second post-cursor coefficient (free mode) |
| amp_out | output | 11 | Signed registered amplitude code |
| amp_valid | output | 1 | High once the history holds real bits |

## Verification
The assertions assume three things. Reset is held over at least one rising clock edge. Coefficient inputs are settled before any enable. An enable never arrives in the same cycle as a reset release. The stimulus drives every input only on the falling clock edge and holds reset for several cycles. It mixes seeded random enables, bits, modes and coefficients with directed cases: impulses, square waves of eight bits per half period, and extreme coefficient codes that reach both saturation limits.

// File: rtl/txffe_pkg.sv
package txffe_pkg;

    // Tap roles in fixed order: 0 pre-cursor, 1 main, 2 post1, 3 post2.
    localparam int NTAPS     = 4;
    localparam int HIST_LEN  = NTAPS - 1;
    localparam int TAP_PRE   = 0;
    localparam int TAP_MAIN  = 1;
    localparam int TAP_POST1 = 2;
    localparam int TAP_POST2 = 3;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_DE35 = 2'd1,
        MODE_DE60 = 2'd2,
        MODE_MAIN = 2'd3
    } ffe_mode_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/txffe_fill_fsm.sv
module txffe_fill_fsm
    import txffe_pkg::*;
#(
    parameter int FILL_LEN = HIST_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ui_en,
    output logic run
);

    localparam int CNT_W = $clog2(FILL_LEN + 1);

    fill_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (ui_en) begin
                    if (cnt_q == CNT_W'(FILL_LEN - 1)) begin
                        state_d = ST_RUN;   // FILL_DONE
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/txffe_history.sv
module txffe_history
    import txffe_pkg::*;
#(
    parameter logic RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ui_en,
    input  logic             bit_in,
    output logic [NTAPS-1:0] taps
);

    logic [HIST_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= {HIST_LEN{RST_BIT}};
        end else if (ui_en) begin
            hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
        end
    end

    // The incoming bit is the advanced tap; older stages follow it.
    assign taps[TAP_PRE] = bit_in;
    for (genvar k = 1; k < NTAPS; k++) begin : g_tap
        assign taps[k] = hist_q[k-1];
    end

endmodule

// File: rtl/txffe_coef_sel.sv
module txffe_coef_sel
    import txffe_pkg::*;
#(
    parameter int CW = 8
) (
    input  ffe_mode_e                 mode,
    input  logic [CW-1:0]             c_pre,
    input  logic [CW-1:0]             c_main,
    input  logic [CW-1:0]             c_post1,
    input  logic [CW-1:0]             c_post2,
    output logic [NTAPS-1:0][CW-1:0]  coef
);

    // Full-scale coefficient code and presets scaled from it so that
    // |main| + |post1| equals full scale.
    localparam int FS_C    = 2 ** (CW - 1) - 1;
    localparam int M35     = (FS_C * 834 + 500) / 1000;
    localparam int P35     = M35 - FS_C;
    localparam int M60     = (FS_C * 750 + 500) / 1000;
    localparam int P60     = M60 - FS_C;

    always_comb begin
        coef = '0;
        unique case (mode)
            MODE_FREE: begin
                coef[TAP_PRE]   = c_pre;
                coef[TAP_MAIN]  = c_main;
                coef[TAP_POST1] = c_post1;
                coef[TAP_POST2] = c_post2;
            end
            MODE_DE35: begin
                coef[TAP_MAIN]  = CW'(M35);
                coef[TAP_POST1] = CW'(P35);
            end
            MODE_DE60: begin
                coef[TAP_MAIN]  = CW'(M60);
                coef[TAP_POST1] = CW'(P60);
            end
            MODE_MAIN: begin
                coef[TAP_MAIN]  = CW'(FS_C);
            end
            default: coef = '0;
        endcase
    end

endmodule

// File: rtl/txffe_mac.sv
module txffe_mac
    import txffe_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [NTAPS-1:0]          taps,
    input  logic [NTAPS-1:0][CW-1:0]  coef,
    output logic signed [CW+2:0]      sum_sat
);

    localparam int ACC_W = CW + 3;
    localparam int FS_O  = 2 ** (CW + 1) - 1;

    logic signed [ACC_W-1:0] term [NTAPS];
    logic signed [ACC_W-1:0] acc;

    for (genvar k = 0; k < NTAPS; k++) begin : g_term
        logic signed [ACC_W-1:0] c_ext;
        assign c_ext   = ACC_W'($signed(coef[k]));
        assign term[k] = taps[k] ? c_ext : -c_ext;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) begin
            acc = acc + term[k];
        end
    end

    always_comb begin
        if (acc > ACC_W'(FS_O)) begin
            sum_sat = ACC_W'(FS_O);
        end else if (acc < -ACC_W'(FS_O)) begin
            sum_sat = -ACC_W'(FS_O);
        end else begin
            sum_sat = acc;
        end
    end

endmodule

// File: rtl/txffe_combiner.sv
module txffe_combiner
    import txffe_pkg::*;
#(
    parameter int   CW      = 8,
    parameter logic RST_BIT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ui_en,
    input  logic                 bit_in,
    input  logic [1:0]           mode_sel,
    input  logic [CW-1:0]        coef_pre,
    input  logic [CW-1:0]        coef_main,
    input  logic [CW-1:0]        coef_post1,
    input  logic [CW-1:0]        coef_post2,
    output logic signed [CW+2:0] amp_out,
    output logic                 amp_valid
);

    logic [NTAPS-1:0]         taps;
    logic [NTAPS-1:0][CW-1:0] coef;
    logic signed [CW+2:0]     sum_sat;
    logic                     run;
    ffe_mode_e                mode;

    assign mode = ffe_mode_e'(mode_sel);

    txffe_fill_fsm #(.FILL_LEN(HIST_LEN)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ui_en (ui_en),
        .run   (run)
    );

    txffe_history #(.RST_BIT(RST_BIT)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .ui_en  (ui_en),
        .bit_in (bit_in),
        .taps   (taps)
    );

    txffe_coef_sel #(.CW(CW)) u_coef (
        .mode    (mode),
        .c_pre   (coef_pre),
        .c_main  (coef_main),
        .c_post1 (coef_post1),
        .c_post2 (coef_post2),
        .coef    (coef)
    );

    txffe_mac #(.CW(CW)) u_mac (
        .taps    (taps),
        .coef    (coef),
        .sum_sat (sum_sat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amp_out   <= '0;
            amp_valid <= 1'b0;
        end else if (ui_en) begin
            if (run) begin
                amp_out   <= sum_sat;
                amp_valid <= 1'b1;
            end else begin
                amp_out   <= '0;
                amp_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txffe_combiner_chk.sv
module txffe_combiner_chk #(
    parameter int CW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ui_en,
    input logic signed [CW+2:0] amp_out,
    input logic                 amp_valid
);

    localparam int FS_O = 2 ** (CW + 1) - 1;

    // R3
    hold_between_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ui_en |=> ($stable(amp_out) && $stable(amp_valid)));

    // R4
    zero_while_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_valid |-> (amp_out == '0));

    // R4
    valid_rises_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_valid) |-> $past(ui_en));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_out <= (CW+3)'(FS_O)) && (amp_out >= -(CW+3)'(FS_O)));

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_valid |=> amp_valid);

endmodule

bind txffe_combiner txffe_combiner_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ui_en     (ui_en),
    .amp_out   (amp_out),
    .amp_valid (amp_valid)
);

// File: tb/txffe_combiner_tb.sv
module txffe_combiner_tb;

    localparam int CW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ui_en = 1'b0;
    logic                 bit_in = 1'b0;
    logic [1:0]           mode_sel = 2'd0;
    logic [CW-1:0]        coef_pre = '0, coef_main = '0, coef_post1 = '0, coef_post2 = '0;
    logic signed [CW+2:0] amp_out;
    logic                 amp_valid;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [2:0] m_hist;
    int         m_cnt;
    int         m_out;
    logic       m_vld;

    always #10 clk = ~clk;

    txffe_combiner #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ui_en(ui_en), .bit_in(bit_in),
        .mode_sel(mode_sel), .coef_pre(coef_pre), .coef_main(coef_main),
        .coef_post1(coef_post1), .coef_post2(coef_post2),
        .amp_out(amp_out), .amp_valid(amp_valid)
    );

    function automatic int sgn8(logic [7:0] v);
        return int'($signed(v));
    endfunction

    // coefficient per tap from the requirement tables (R1, R5, R6, R7)
    function automatic int model_coef(int mode, int k);
        int c[4];
        case (mode)
            1: c = '{0, 106, -21, 0};
            2: c = '{0, 95, -32, 0};
            3: c = '{0, 127, 0, 0};
            default: c = '{sgn8(coef_pre), sgn8(coef_main), sgn8(coef_post1), sgn8(coef_post2)};
        endcase
        return c[k];
    endfunction

    function automatic int sat511(int v);
        if (v > 511) return 511;
        if (v < -511) return -511;
        return v;
    endfunction

    task automatic model_reset();
        m_hist = 3'b000;
        m_cnt  = 0;
        m_out  = 0;
        m_vld  = 1'b0;
    endtask

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, advance the model, wait one edge, compare.
    task automatic cycle(logic en, logic b, string tag);
        logic [3:0] t;
        int acc;
        ui_en  = en;
        bit_in = b;
        if (en) begin
            t = {m_hist, b};   // t[0] newest (pre), t[1] main, t[2] post1, t[3] post2
            acc = 0;
            for (int k = 0; k < 4; k++)
                acc += model_coef(int'(mode_sel), k) * (t[k] ? 1 : -1);
            if (m_cnt >= 3) begin
                m_out = sat511(acc);
                m_vld = 1'b1;
            end else begin
                m_out = 0;
                m_vld = 1'b0;
            end
            m_hist = {m_hist[1:0], b};
            m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(amp_out), m_out, "amp_out");
        check(tag, int'(amp_valid), int'(m_vld), "amp_valid");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ui_en = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R4", int'(amp_out), 0, "amp_out in reset");
        check("R4", int'(amp_valid), 0, "amp_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // square wave, 8 bits per half period, literal levels per requirement
    task automatic square(int mode, int tr, int rp, string tag);
        logic prev;
        logic cur;
        mode_sel = 2'(mode);
        coef_pre = 8'h55; coef_main = 8'hAA; coef_post1 = 8'h33; coef_post2 = 8'hCC;
        prev = 1'b0;
        for (int n = 0; n < 48; n++) begin
            cur = ((n / 8) % 2) == 1;
            cycle(1'b1, cur, tag);
            if (n >= 10) begin
                // main cursor = previous bit (prev), post1 = bit before it
                int lvl;
                lvl = (prev != m_hist[2]) ? tr : rp;
                check(tag, int'(amp_out), prev ? lvl : -lvl, "level");
            end
            prev = cur;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        model_reset();
        @(negedge clk);
        do_reset();

        // R4: three filling enables give zero, fourth gives a real sum
        mode_sel = 2'd0;
        coef_pre = 8'hF6; coef_main = 8'd90; coef_post1 = 8'hEC; coef_post2 = 8'd5;
        cycle(1'b1, 1'b1, "R4");
        cycle(1'b1, 1'b1, "R4");
        cycle(1'b1, 1'b1, "R4");
        cycle(1'b1, 1'b1, "R4");
        check("R4", int'(amp_out), -10 + 90 - 20 + 5, "first sum");

        // R2: single one in zeros, coefficients distinct
        for (int n = 0; n < 6; n++) cycle(1'b1, 1'b0, "R2");
        cycle(1'b1, 1'b1, "R2");
        check("R2", int'(amp_out), -(-10) - 90 + 20 - 5 + 2 * (-10), "pre tap");
        cycle(1'b1, 1'b0, "R2");
        check("R2", int'(amp_out), 10 + 90 + 20 - 5, "main tap");
        cycle(1'b1, 1'b0, "R2");
        check("R2", int'(amp_out), 10 - 90 - 20 - 5, "post1 tap");
        cycle(1'b1, 1'b0, "R2");
        check("R2", int'(amp_out), 10 - 90 + 20 + 5, "post2 tap");

        // R3: inputs wiggle while enable is low
        for (int n = 0; n < 6; n++) begin
            mode_sel = 2'(n % 4);
            coef_main = 8'($urandom);
            cycle(1'b0, n[0], "R3");
        end
        mode_sel = 2'd0;
        coef_main = 8'd90;

        // R1: directed sign mix with positive post2
        coef_pre = 8'hE0; coef_main = 8'd100; coef_post1 = 8'hC0; coef_post2 = 8'd12;
        cycle(1'b1, 1'b0, "R1");
        cycle(1'b1, 1'b1, "R1");
        cycle(1'b1, 1'b1, "R1");
        cycle(1'b1, 1'b0, "R1");

        // R5, R6, R7: presets over square waves
        square(1, 127, 85, "R5");
        square(2, 127, 63, "R6");
        square(3, 127, 127, "R7");

        // R8: saturation both ways, and an in-range extreme
        mode_sel = 2'd0;
        coef_pre = 8'h80; coef_main = 8'h80; coef_post1 = 8'h80; coef_post2 = 8'h80;
        for (int n = 0; n < 4; n++) cycle(1'b1, 1'b0, "R8");
        check("R8", int'(amp_out), 511, "positive clip");
        for (int n = 0; n < 4; n++) cycle(1'b1, 1'b1, "R8");
        check("R8", int'(amp_out), -511, "negative clip");
        coef_pre = 8'd127; coef_main = 8'd127; coef_post1 = 8'd127; coef_post2 = 8'd127;
        for (int n = 0; n < 4; n++) cycle(1'b1, 1'b1, "R8");
        check("R8", int'(amp_out), 508, "in range");

        // R4: reset in the middle of a run and refill
        do_reset();
        for (int n = 0; n < 5; n++) cycle(1'b1, 1'b1, "R4");

        // R1, R3, R9: seeded random traffic
        for (int n = 0; n < 1500; n++) begin
            if (($urandom % 16) == 0) mode_sel = 2'($urandom);
            if (($urandom % 8) == 0) begin
                coef_pre   = 8'($urandom);
                coef_main  = 8'($urandom);
                coef_post1 = 8'($urandom);
                coef_post2 = 8'($urandom);
            end
            cycle(($urandom % 4) != 0, 1'($urandom), "R1");
        end
        check("R9", int'(amp_valid), 1, "valid held");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule